// File: doc/BRIEF.md
# Shared-Bus Ownership Sequencer

This block sits on the master side of a shared external bus that an outside arbiter controls. When local logic has a transfer to make, the block raises a bus request. It then waits for the arbiter's grant. Once the grant is present, it waits until the current owner lets go of the shared busy line. It then claims the bus by driving busy high itself, and at that same moment it withdraws its request. The transfer runs through a start pulse and a done strobe. Afterwards the block hands the bus back. It drives busy low for one cycle and then stops driving the line.

The busy line is bidirectional. It is modelled as an observed input plus a driven value with its own output enable. The block passes through five states: idle, requesting, waiting for the bus to go free, owning the bus, and releasing it. Every pin it drives comes from a flop. When another transfer is already queued at release time, the parameter `EARLY_REREQ` lets the request be raised again during the release cycle instead of one cycle later.

Top module: `bus_claim_fsm`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `bus_req_o`, `busy_out_o`, `busy_oe_o` and `xfer_start_o` are all 0, including when reset arrives during ownership.
- R2: From idle, a high `xfer_req_i` at a clock edge makes `bus_req_o` 1 after that edge. The request then stays at 1 until ownership is taken.
- R3: While requesting, the block neither drives nor enables busy if `bus_grant_i` is 0 or `busy_in_i` is 1.
- R4: At the first edge where the block has already seen the grant (it has passed one edge with grant high since requesting), `bus_grant_i` is still 1 and `busy_in_i` is 0, it sets `busy_out_o`=1 and `busy_oe_o`=1. It clears `bus_req_o` at the same edge and pulses `xfer_start_o` for exactly one cycle.
- R5: If the grant is withdrawn after it has been seen but before ownership, the block returns to requesting. `bus_req_o` stays 1 and busy is not driven.
- R6: `busy_out_o` stays 1 until an edge with `xfer_done_i`=1. `xfer_done_i` has no effect outside ownership.
- R7: After done, there is exactly one release cycle with `busy_out_o`=0 and `busy_oe_o`=1. If no transfer is queued, all outputs are 0 after that.
- R8: If `xfer_req_i` is 1 at the done edge, `bus_req_o` is 1 during the release cycle (with `EARLY_REREQ`=1) and stays 1 afterwards.
- R9: `bus_req_o` and `busy_out_o` are never both 1, and `busy_out_o`=1 always comes with `busy_oe_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req_i | input | 1 | Local logic has a transfer pending |
| xfer_done_i | input | 1 | Strobe marking the end of the transfer |
| xfer_start_o | output | 1 | One-cycle pulse when ownership begins |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_grant_i | input | 1 | Grant from the arbiter |
| busy_in_i | input | 1 | Observed level of the shared busy line |
| busy_out_o | output | 1 | Value driven onto the busy line |
| busy_oe_o | output | 1 | Output enable for the busy line |

## Verification
The assertions check several rules on every cycle. Ownership may only begin after a cycle in which the grant was high and busy was free. Request and busy are never high together, and the driven value is always enabled. Every fall of busy is followed by one enabled low cycle. A withdrawn grant leads back to a plain request. Only the bench scenarios can show the full orderings. These include how long the block waits under a held busy line, that a done strobe outside ownership is ignored, that a queued request carries through the release cycle, and that a reset during ownership drops every driven pin.

// File: rtl/bus_claim_pkg.sv
package bus_claim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_WAIT    = 3'd2,
    ST_OWN     = 3'd3,
    ST_RELEASE = 3'd4
  } claim_state_t;

  typedef struct packed {
    logic req;
    logic busy;
    logic oe;
    logic start;
  } claim_out_t;

  // Pin values for the state about to be entered; start marks the entry edge.
  function automatic claim_out_t pins_for(claim_state_t ns, claim_state_t cs,
                                          logic queued, logic early);
    claim_out_t o;
    o.req   = (ns == ST_REQ) || (ns == ST_WAIT) ||
              (early && (ns == ST_RELEASE) && queued);
    o.busy  = (ns == ST_OWN);
    o.oe    = (ns == ST_OWN) || (ns == ST_RELEASE);
    o.start = (ns == ST_OWN) && (cs != ST_OWN);
    return o;
  endfunction

endpackage

// File: rtl/bus_claim_step.sv
module bus_claim_step
  import bus_claim_pkg::*;
(
  input  claim_state_t cur,
  input  logic         xfer_req,
  input  logic         xfer_done,
  input  logic         grant,
  input  logic         busy_seen,
  output claim_state_t nxt,
  output logic         ev_take,
  output logic         ev_withdraw,
  output logic         ev_finish
);

  assign ev_take     = (cur == ST_WAIT) && grant && !busy_seen;
  assign ev_withdraw = (cur == ST_WAIT) && !grant;
  assign ev_finish   = (cur == ST_OWN) && xfer_done;

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_IDLE:    if (xfer_req) nxt = ST_REQ;
      ST_REQ:     if (grant) nxt = ST_WAIT;
      ST_WAIT: begin
        if (ev_withdraw)  nxt = ST_REQ;
        else if (ev_take) nxt = ST_OWN;
      end
      ST_OWN:     if (ev_finish) nxt = ST_RELEASE;
      ST_RELEASE: nxt = xfer_req ? ST_REQ : ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bus_claim_drive.sv
module bus_claim_drive
  import bus_claim_pkg::*;
#(
  parameter bit EARLY_REREQ = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  claim_state_t cs,
  input  claim_state_t ns,
  input  logic         queued,
  output logic         req_q,
  output logic         busy_q,
  output logic         oe_q,
  output logic         start_q
);

  claim_out_t pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= pins_for(ns, cs, queued, EARLY_REREQ);
  end

  assign req_q   = pins_q.req;
  assign busy_q  = pins_q.busy;
  assign oe_q    = pins_q.oe;
  assign start_q = pins_q.start;

  assert_no_req_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_q && busy_q));

  assert_busy_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> oe_q);

  assert_release_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (oe_q && !busy_q));

  assert_release_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |=> !oe_q);

endmodule

// File: rtl/bus_claim_fsm.sv
module bus_claim_fsm
  import bus_claim_pkg::*;
#(
  parameter bit EARLY_REREQ = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req_i,
  input  logic xfer_done_i,
  output logic xfer_start_o,
  output logic bus_req_o,
  input  logic bus_grant_i,
  input  logic busy_in_i,
  output logic busy_out_o,
  output logic busy_oe_o
);

  claim_state_t state_q, state_d;
  logic ev_take, ev_withdraw, ev_finish;

  bus_claim_step u_step (
    .cur        (state_q),
    .xfer_req   (xfer_req_i),
    .xfer_done  (xfer_done_i),
    .grant      (bus_grant_i),
    .busy_seen  (busy_in_i),
    .nxt        (state_d),
    .ev_take    (ev_take),
    .ev_withdraw(ev_withdraw),
    .ev_finish  (ev_finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  bus_claim_drive #(.EARLY_REREQ(EARLY_REREQ)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (state_q),
    .ns     (state_d),
    .queued (xfer_req_i),
    .req_q  (bus_req_o),
    .busy_q (busy_out_o),
    .oe_q   (busy_oe_o),
    .start_q(xfer_start_o)
  );

  assert_take_needs_free_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_out_o) |-> $past(bus_grant_i && !busy_in_i));

  assert_take_pulses_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_out_o) |-> xfer_start_o);

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_o |=> !xfer_start_o);

  assert_withdraw_requeue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_withdraw |=> (bus_req_o && !busy_oe_o));

  assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_out_o && !xfer_done_i) |=> busy_out_o);

  assert_finish_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (!busy_out_o && busy_oe_o));

  assert_take_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> (busy_out_o && !bus_req_o));

endmodule

// File: tb/bus_claim_fsm_test.sv
module bus_claim_fsm_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_req = 1'b0, xfer_done = 1'b0, grant = 1'b0, busy_in = 1'b1;
  logic start, req, busy_out, busy_oe;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_claim_fsm uut (
    .clk(clk), .rst_n(rst_n),
    .xfer_req_i(xfer_req), .xfer_done_i(xfer_done), .xfer_start_o(start),
    .bus_req_o(req), .bus_grant_i(grant), .busy_in_i(busy_in),
    .busy_out_o(busy_out), .busy_oe_o(busy_oe)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pins(string tag, logic e_req, logic e_busy, logic e_oe, logic e_start);
    logic [3:0] act, exp;
    act = {req, busy_out, busy_oe, start};
    exp = {e_req, e_busy, e_oe, e_start};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s req/busy/oe/start actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    xfer_req = 0; xfer_done = 0; grant = 0; busy_in = 1;
    repeat (3) step();
    pins("R1 during reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    step();
    pins("R1 after reset", 0, 0, 0, 0);
  endtask

  // Finish an ownership from OWN with nothing queued.
  task automatic finish_owned();
    xfer_req = 0; xfer_done = 1;
    step();
    pins("R7 release cycle", 0, 0, 1, 0);
    xfer_done = 0;
    step();
    pins("R7 idle after release", 0, 0, 0, 0);
    grant = 0; busy_in = 1;
  endtask

  task automatic t_basic();
    xfer_req = 1;
    step();
    pins("R2 request raised", 1, 0, 0, 0);
    repeat (3) begin
      step();
      pins("R3 no grant, no drive", 1, 0, 0, 0);
    end
    grant = 1;
    step();
    pins("R3 grant seen, busy held", 1, 0, 0, 0);
    step();
    pins("R3 still waiting on busy", 1, 0, 0, 0);
    busy_in = 0;
    step();
    pins("R4 ownership taken, R9 req low", 0, 1, 1, 1);
    xfer_req = 0;
    step();
    pins("R6 held, R4 start single", 0, 1, 1, 0);
    step();
    pins("R6 held without done", 0, 1, 1, 0);
    finish_owned();
  endtask

  task automatic t_withdraw();
    xfer_req = 1; grant = 1; busy_in = 1;
    step();
    pins("R2 request", 1, 0, 0, 0);
    step();
    pins("R3 wait with busy", 1, 0, 0, 0);
    grant = 0;
    step();
    pins("R5 grant withdrawn", 1, 0, 0, 0);
    busy_in = 0;
    step();
    pins("R5 still requesting, no take", 1, 0, 0, 0);
    grant = 1;
    step();
    pins("R5 grant back, waiting", 1, 0, 0, 0);
    step();
    pins("R4 taken after regrant", 0, 1, 1, 1);
    finish_owned();
  endtask

  task automatic t_queued();
    xfer_req = 1; grant = 1; busy_in = 0;
    step(); step(); step();
    pins("R4 owned", 0, 1, 1, 1);
    xfer_done = 1;
    step();
    pins("R8 release with queued request", 1, 0, 1, 0);
    xfer_done = 0;
    step();
    pins("R8 request kept after release", 1, 0, 0, 0);
    xfer_req = 0;
    step();
    pins("R8 waiting", 1, 0, 0, 0);
    step();
    pins("R4 second ownership", 0, 1, 1, 1);
    finish_owned();
  endtask

  task automatic t_done_ignored();
    xfer_done = 1;
    step();
    pins("R6 done in idle ignored", 0, 0, 0, 0);
    xfer_done = 0; xfer_req = 1; grant = 0; busy_in = 1;
    step();
    xfer_done = 1;
    step();
    pins("R6 done while requesting ignored", 1, 0, 0, 0);
    grant = 1;
    step();
    step();
    pins("R6 done while waiting ignored", 1, 0, 0, 0);
    xfer_done = 0; busy_in = 0;
    step();
    pins("R4 owned after ignored done", 0, 1, 1, 1);
    finish_owned();
  endtask

  task automatic t_reset_owned();
    xfer_req = 1; grant = 1; busy_in = 0;
    step(); step(); step(); step();
    pins("R6 owned before reset", 0, 1, 1, 0);
    do_reset();
  endtask

  initial begin
    do_reset();
    t_basic();
    t_withdraw();
    t_queued();
    t_done_ignored();
    t_reset_owned();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule